// File: doc/BRIEF.md
# Bidirectional Double-Data-Rate Pad Register Path

This block sits between core logic and one bidirectional pad group and carries data at double rate in both directions. On the transmit side it holds two words, one loaded on each edge of the output clock. A multiplexer steered by the clock level sends one word out during each half period. A bypass lets the core drive the pad directly with no register in the way. On the receive side the pad is sampled on both edges of the input clock. The falling-edge sample is carried forward so that both halves of a bit pair reach the core together on the following rising edge.

The drive enable goes through two registers. The first register loads the core enable on the rising edge. The second copies it half a period later. A select line ORs the delayed copy into the final enable, which lengthens the drive window by half a clock period. That extra half period is what a write strobe or write clock for a memory needs. The tristate control at the pad is active low by default. The core-side enable polarity and both clock polarities can be inverted by parameter. The receive outputs can be forced to zero, so that the same path can run as a pure strobe generator.

Top module: `ddr_bidir_pad_path`

## Requirements
- R1: While the active-high asynchronous reset `rst` is 1, all data and enable registers are cleared. `pad_tri_ctl` is then at its idle level (1 with the default active-low setting, meaning the pad is released), `pad_out` is 0, and `rx_hi` and `rx_lo` are 0. This holds even when reset arrives between clock edges.
- R2: `tx_hi` is registered on each rising edge of the output clock and appears on `pad_out` while the output clock is high.
- R3: `tx_lo` is registered on each falling edge of the output clock and appears on `pad_out` while the output clock is low.
- R4: While `bypass_en` is 1, `pad_out` equals `tx_hi` combinationally, with no clock edge needed, in either clock half.
- R5: With `oe_half_sel` = 0, `pad_tri_ctl` goes to 0 (drive) at the first rising edge that samples `oe_core` = 1. It returns to 1 (released) at the first rising edge that samples `oe_core` = 0.
- R6: With `oe_half_sel` = 1, the drive window starts at the same rising edge as in R5. It ends at the falling edge that follows the rising edge sampling `oe_core` = 0, which is exactly half a clock period later than in R5.
- R7: The pad level sampled at rising input-clock edge k appears on `rx_hi`, and the level sampled at the falling edge after k appears on `rx_lo`. Both update together at rising edge k+1 and hold until the next rising edge.
- R8: While `rx_off` is 1, `rx_hi` and `rx_lo` are 0. Capture continues underneath, so clearing `rx_off` shows the latest captured pair at once.
- R9: While the enable registers hold 0, `oe_half_sel` has no effect. `pad_tri_ctl` stays at 1 however the select is toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high |
| out_clk | input | 1 | Output-side clock (polarity set by parameter) |
| in_clk | input | 1 | Input-side clock (polarity set by parameter) |
| tx_hi | input | W | Word driven during the high half of the output clock |
| tx_lo | input | W | Word driven during the low half of the output clock |
| oe_core | input | 1 | Core drive enable (active high by default) |
| oe_half_sel | input | 1 | 1 adds the half-period-delayed enable to the window |
| bypass_en | input | 1 | 1 routes `tx_hi` straight to the pad |
| rx_off | input | 1 | 1 forces the receive outputs to zero |
| pad_in | input | W | Level seen at the pad |
| pad_out | output | W | Value the pad driver presents |
| pad_tri_ctl | output | 1 | Tristate control, 0 = drive with default polarity |
| rx_hi | output | W | Rising-edge half of the received pair |
| rx_lo | output | W | Falling-edge half of the received pair |

## Verification
The bench measures the enable window at both ends, in each half period. A design that took the delayed copy on the wrong edge, or that let it lengthen the start of the window, would release or grab the pad half a period off, and a check placed on either side of the expected edge catches this. Receive data uses pad patterns whose rising and falling samples differ. A design that swapped the two halves, or that moved them one edge early, shows the wrong word. Reset asserted between edges, bypass changed with no edge, and `rx_off` released with no edge each expose a design that waits for a clock where none should be needed.

// File: rtl/ddr_pad_pkg.sv
package ddr_pad_pkg;

  // Apply an optional inversion to a control or clock level.
  function automatic logic apply_pol(input logic lvl, input bit inv);
    return lvl ^ inv;
  endfunction

  // Final drive request: the rising-edge enable, widened by the
  // half-period copy only when the select asks for it.
  function automatic logic oe_merge(input logic rise_q, input logic half_q,
                                    input logic sel);
    return rise_q | (sel & half_q);
  endfunction

  // Level of the pad tristate control for a given drive request.
  function automatic logic tri_level(input logic drive, input bit active_low);
    return active_low ? ~drive : drive;
  endfunction

endpackage

// File: rtl/ddr_out_path.sv
module ddr_out_path #(
  parameter int W = 4
) (
  input  logic         oclk,
  input  logic         rst,
  input  logic [W-1:0] tx_hi,
  input  logic [W-1:0] tx_lo,
  input  logic         bypass_en,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] pad_out
);

  logic [W-1:0] ddr_sel;

  always_ff @(posedge oclk or posedge rst) begin
    if (rst) hi_q <= '0;
    else     hi_q <= tx_hi;
  end

  always_ff @(negedge oclk or posedge rst) begin
    if (rst) lo_q <= '0;
    else     lo_q <= tx_lo;
  end

  // Clock level picks the half; one mux per bit.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign ddr_sel[b] = oclk ? hi_q[b] : lo_q[b];
  end

  assign pad_out = bypass_en ? tx_hi : ddr_sel;

endmodule

// File: rtl/ddr_oe_path.sv
module ddr_oe_path #(
  parameter bit TRI_ACTIVE_LOW = 1'b1
) (
  input  logic oclk,
  input  logic rst,
  input  logic oe_req,
  input  logic oe_half_sel,
  output logic oe_rise_q,
  output logic oe_half_q,
  output logic oe_merged,
  output logic pad_tri_ctl
);

  import ddr_pad_pkg::*;

  always_ff @(posedge oclk or posedge rst) begin
    if (rst) oe_rise_q <= 1'b0;
    else     oe_rise_q <= oe_req;
  end

  always_ff @(negedge oclk or posedge rst) begin
    if (rst) oe_half_q <= 1'b0;
    else     oe_half_q <= oe_rise_q;
  end

  assign oe_merged   = oe_merge(oe_rise_q, oe_half_q, oe_half_sel);
  assign pad_tri_ctl = tri_level(oe_merged, TRI_ACTIVE_LOW);

endmodule

// File: rtl/ddr_in_path.sv
module ddr_in_path #(
  parameter int W = 4
) (
  input  logic         iclk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  input  logic         rx_off,
  output logic [W-1:0] rise_cap,
  output logic [W-1:0] fall_cap,
  output logic [W-1:0] pair_hi,
  output logic [W-1:0] pair_lo,
  output logic [W-1:0] rx_hi,
  output logic [W-1:0] rx_lo
);

  always_ff @(posedge iclk or posedge rst) begin
    if (rst) rise_cap <= '0;
    else     rise_cap <= pad_in;
  end

  always_ff @(negedge iclk or posedge rst) begin
    if (rst) fall_cap <= '0;
    else     fall_cap <= pad_in;
  end

  // Realign: both halves of one bit pair move to the core together.
  always_ff @(posedge iclk or posedge rst) begin
    if (rst) begin
      pair_hi <= '0;
      pair_lo <= '0;
    end else begin
      pair_hi <= rise_cap;
      pair_lo <= fall_cap;
    end
  end

  assign rx_hi = rx_off ? '0 : pair_hi;
  assign rx_lo = rx_off ? '0 : pair_lo;

endmodule

// File: rtl/ddr_bidir_pad_path.sv
module ddr_bidir_pad_path #(
  parameter int W                  = 4,
  parameter bit OUTCLK_INV         = 1'b0,
  parameter bit INCLK_INV          = 1'b0,
  parameter bit OE_CORE_ACTIVE_LOW = 1'b0,
  parameter bit TRI_ACTIVE_LOW     = 1'b1
) (
  input  logic         rst,
  input  logic         out_clk,
  input  logic         in_clk,
  input  logic [W-1:0] tx_hi,
  input  logic [W-1:0] tx_lo,
  input  logic         oe_core,
  input  logic         oe_half_sel,
  input  logic         bypass_en,
  input  logic         rx_off,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic         pad_tri_ctl,
  output logic [W-1:0] rx_hi,
  output logic [W-1:0] rx_lo
);

  import ddr_pad_pkg::*;

  // Named internal events, visible to the bound checker.
  logic         oclk;
  logic         iclk;
  logic         oe_req;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic         oe_rise_q;
  logic         oe_half_q;
  logic         oe_merged;
  logic [W-1:0] rise_cap;
  logic [W-1:0] fall_cap;
  logic [W-1:0] pair_hi;
  logic [W-1:0] pair_lo;

  if (OUTCLK_INV) begin : g_oclk_inv
    assign oclk = ~out_clk;
  end else begin : g_oclk_dir
    assign oclk = out_clk;
  end

  if (INCLK_INV) begin : g_iclk_inv
    assign iclk = ~in_clk;
  end else begin : g_iclk_dir
    assign iclk = in_clk;
  end

  assign oe_req = apply_pol(oe_core, OE_CORE_ACTIVE_LOW);

  ddr_out_path #(.W(W)) u_out (
    .oclk      (oclk),
    .rst       (rst),
    .tx_hi     (tx_hi),
    .tx_lo     (tx_lo),
    .bypass_en (bypass_en),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .pad_out   (pad_out)
  );

  ddr_oe_path #(.TRI_ACTIVE_LOW(TRI_ACTIVE_LOW)) u_oe (
    .oclk        (oclk),
    .rst         (rst),
    .oe_req      (oe_req),
    .oe_half_sel (oe_half_sel),
    .oe_rise_q   (oe_rise_q),
    .oe_half_q   (oe_half_q),
    .oe_merged   (oe_merged),
    .pad_tri_ctl (pad_tri_ctl)
  );

  ddr_in_path #(.W(W)) u_in (
    .iclk     (iclk),
    .rst      (rst),
    .pad_in   (pad_in),
    .rx_off   (rx_off),
    .rise_cap (rise_cap),
    .fall_cap (fall_cap),
    .pair_hi  (pair_hi),
    .pair_lo  (pair_lo),
    .rx_hi    (rx_hi),
    .rx_lo    (rx_lo)
  );

endmodule

// File: rtl/ddr_bidir_pad_path_chk.sv
module ddr_bidir_pad_path_chk #(
  parameter int W              = 4,
  parameter bit TRI_ACTIVE_LOW = 1'b1
) (
  input logic         oclk,
  input logic         iclk,
  input logic         rst,
  input logic [W-1:0] tx_hi,
  input logic [W-1:0] tx_lo,
  input logic         oe_req,
  input logic         oe_half_sel,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         oe_rise_q,
  input logic         oe_half_q,
  input logic         pad_tri_ctl,
  input logic [W-1:0] rise_cap,
  input logic [W-1:0] fall_cap,
  input logic [W-1:0] pair_hi,
  input logic [W-1:0] pair_lo,
  input logic         rx_off,
  input logic [W-1:0] rx_hi,
  input logic [W-1:0] rx_lo
);

  localparam logic IDLE_LVL = TRI_ACTIVE_LOW;

  assert_hi_load_R2: assert property (@(posedge oclk) disable iff (rst)
    !rst |=> (hi_q == $past(tx_hi)));

  assert_lo_load_R3: assert property (@(negedge oclk) disable iff (rst)
    !rst |=> (lo_q == $past(tx_lo)));

  assert_oe_rise_R5: assert property (@(posedge oclk) disable iff (rst)
    !rst |=> (oe_rise_q == $past(oe_req)));

  assert_drive_on_R5: assert property (@(posedge oclk) disable iff (rst)
    oe_rise_q |-> (pad_tri_ctl != IDLE_LVL));

  assert_oe_half_R6: assert property (@(negedge oclk) disable iff (rst)
    !rst |=> (oe_half_q == $past(oe_rise_q)));

  assert_stretch_hold_R6: assert property (@(posedge oclk) disable iff (rst)
    (oe_half_sel && oe_half_q) |-> (pad_tri_ctl != IDLE_LVL));

  assert_release_rise_R9: assert property (@(posedge oclk) disable iff (rst)
    (!oe_rise_q && !(oe_half_sel && oe_half_q)) |-> (pad_tri_ctl == IDLE_LVL));

  assert_release_fall_R9: assert property (@(negedge oclk) disable iff (rst)
    (!oe_rise_q && !(oe_half_sel && oe_half_q)) |-> (pad_tri_ctl == IDLE_LVL));

  assert_pair_align_R7: assert property (@(posedge iclk) disable iff (rst)
    !rst |=> (pair_hi == $past(rise_cap)) && (pair_lo == $past(fall_cap)));

  assert_rx_gate_R8: assert property (@(posedge iclk) disable iff (rst)
    rx_off |-> (rx_hi == '0) && (rx_lo == '0));

endmodule

bind ddr_bidir_pad_path ddr_bidir_pad_path_chk #(
  .W(W),
  .TRI_ACTIVE_LOW(TRI_ACTIVE_LOW)
) u_chk (
  .oclk        (oclk),
  .iclk        (iclk),
  .rst         (rst),
  .tx_hi       (tx_hi),
  .tx_lo       (tx_lo),
  .oe_req      (oe_req),
  .oe_half_sel (oe_half_sel),
  .hi_q        (hi_q),
  .lo_q        (lo_q),
  .oe_rise_q   (oe_rise_q),
  .oe_half_q   (oe_half_q),
  .pad_tri_ctl (pad_tri_ctl),
  .rise_cap    (rise_cap),
  .fall_cap    (fall_cap),
  .pair_hi     (pair_hi),
  .pair_lo     (pair_lo),
  .rx_off      (rx_off),
  .rx_hi       (rx_hi),
  .rx_lo       (rx_lo)
);

// File: tb/ddr_bidir_pad_path_tb.sv
module ddr_bidir_pad_path_tb;

  localparam int W = 4;
  localparam int NVEC = 8;
  // Each entry: {tx_hi, tx_lo, pad level at rise, pad level at fall}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h5A3C, 16'hF00F, 16'h0FF0, 16'h1234,
    16'h8E71, 16'hC396, 16'h7B4D, 16'h0000
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] tx_hi = '0;
  logic [W-1:0] tx_lo = '0;
  logic         oe_core = 1'b0;
  logic         oe_half_sel = 1'b0;
  logic         bypass_en = 1'b0;
  logic         rx_off = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out;
  logic         pad_tri_ctl;
  logic [W-1:0] rx_hi;
  logic [W-1:0] rx_lo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_bidir_pad_path u_dut (
    .rst         (rst),
    .out_clk     (clk),
    .in_clk      (clk),
    .tx_hi       (tx_hi),
    .tx_lo       (tx_lo),
    .oe_core     (oe_core),
    .oe_half_sel (oe_half_sel),
    .bypass_en   (bypass_en),
    .rx_off      (rx_off),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_tri_ctl (pad_tri_ctl),
    .rx_hi       (rx_hi),
    .rx_lo       (rx_lo)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one drive-window experiment; sel picks the stretch.
  task automatic oe_window(input logic sel);
    oe_half_sel = sel;
    @(posedge clk); #1 oe_core = 1'b1;
    #2 chk("R5 idle before start edge", 8'(pad_tri_ctl), 8'h1);
    @(posedge clk); #1 chk("R5 drive from start edge", 8'(pad_tri_ctl), 8'h0);
    @(posedge clk); #1 oe_core = 1'b0;
    @(negedge clk); #1 chk("R5 drive before end edge", 8'(pad_tri_ctl), 8'h0);
    @(posedge clk); #1;
    if (sel) begin
      chk("R6 drive after end edge", 8'(pad_tri_ctl), 8'h0);
      #3 chk("R6 drive late high half", 8'(pad_tri_ctl), 8'h0);
      @(negedge clk); #1 chk("R6 release half period later", 8'(pad_tri_ctl), 8'h1);
    end else begin
      chk("R5 release at end edge", 8'(pad_tri_ctl), 8'h1);
      @(negedge clk); #1 chk("R5 still released", 8'(pad_tri_ctl), 8'h1);
    end
  endtask

  initial begin : main
    #2;
    chk("R1 tristate idle in reset", 8'(pad_tri_ctl), 8'h1);
    chk("R1 pad_out zero in reset", 8'(pad_out), 8'h0);
    chk("R1 rx_hi zero in reset", 8'(rx_hi), 8'h0);
    chk("R1 rx_lo zero in reset", 8'(rx_lo), 8'h0);
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;

    // Drive window, normal then stretched.
    oe_window(1'b0);
    oe_window(1'b1);

    // R9: select toggled with no enable pending.
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1 oe_half_sel = ~oe_half_sel;
      #2 chk("R9 select ignored high half", 8'(pad_tri_ctl), 8'h1);
      @(negedge clk); #1 oe_half_sel = ~oe_half_sel;
      #2 chk("R9 select ignored low half", 8'(pad_tri_ctl), 8'h1);
    end

    // Vector table: R2, R3 on transmit; R7 on receive.
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      @(posedge clk); #1;
      tx_hi = v[15:12]; tx_lo = v[11:8]; pad_in = v[7:4];
      @(posedge clk); #1 pad_in = v[3:0];
      #2 chk("R2 high half word", 8'(pad_out), 8'(v[15:12]));
      @(negedge clk); #3 chk("R3 low half word", 8'(pad_out), 8'(v[11:8]));
      @(posedge clk); #3;
      chk("R7 rise sample on rx_hi", 8'(rx_hi), 8'(v[7:4]));
      chk("R7 fall sample on rx_lo", 8'(rx_lo), 8'(v[3:0]));
      @(negedge clk); #3;
      chk("R7 rx_hi held", 8'(rx_hi), 8'(v[7:4]));
      chk("R7 rx_lo held", 8'(rx_lo), 8'(v[3:0]));
    end

    // R4: bypass without any edge, in both halves.
    @(posedge clk); #1 bypass_en = 1'b1; tx_hi = 4'h6; tx_lo = 4'h9;
    #1 chk("R4 bypass high half", 8'(pad_out), 8'h6);
    @(negedge clk); #1 tx_hi = 4'hD;
    #1 chk("R4 bypass low half", 8'(pad_out), 8'hD);
    @(posedge clk); #1 bypass_en = 1'b0;

    // R8: gated receive, then release shows latest pair.
    rx_off = 1'b1;
    @(posedge clk); #1 pad_in = 4'h9;
    @(posedge clk); #1 pad_in = 4'h6;
    @(posedge clk); #3;
    chk("R8 rx_hi forced zero", 8'(rx_hi), 8'h0);
    chk("R8 rx_lo forced zero", 8'(rx_lo), 8'h0);
    rx_off = 1'b0;
    #1;
    chk("R8 rx_hi after release", 8'(rx_hi), 8'h9);
    chk("R8 rx_lo after release", 8'(rx_lo), 8'h6);

    // R1: reset between edges while driving.
    oe_core = 1'b1; tx_hi = 4'hB; tx_lo = 4'h4;
    repeat (2) @(posedge clk);
    #1 chk("R1 driving before reset", 8'(pad_tri_ctl), 8'h0);
    #1 rst = 1'b1;
    #1;
    chk("R1 async reset releases pad", 8'(pad_tri_ctl), 8'h1);
    chk("R1 async reset clears pad_out", 8'(pad_out), 8'h0);
    chk("R1 async reset clears rx_hi", 8'(rx_hi), 8'h0);
    chk("R1 async reset clears rx_lo", 8'(rx_lo), 8'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule